// File: doc/BRIEF.md
# Critical-Word-First Line Fill Cache

This block is a direct-mapped read cache that sits between a processor's word-read port and a word-wide memory port. A processor word address is split into three fields. The lowest bits pick a word inside a line. The next bits pick one line of the cache. The remaining high bits form a tag, which is kept per line and compared on every lookup. A lookup that finds a valid line with a matching tag returns data without touching memory.

On a miss the block refills the whole aligned line that holds the missed word. The refill does not begin at the line base. It begins with the missed word and then walks upward through the line, wrapping past the last word back to word 0. The missed word is handed to the processor in the same cycle it comes back from memory, so the stall ends there. The other words of the line keep arriving in the background.

While a refill runs, a further request is served only if it reads a word of the filling line that has already been written, or the word arriving in that cycle. Any other request waits until the refill ends. Lines sit on boundaries equal to their size, so two addresses that are a whole cache size apart (LINES*WORDS words) share a line and evict each other.

Top module: `cwf_cache`

## Requirements
- R1: After reset no line is valid. Every first request misses: `cpu_stall` is high and a memory request follows.
- R2: The word address splits into three fields. The offset is bits [OFF_W-1:0], the line index is the next IDX_W bits, and the tag is the rest. A request hits when the indexed line is valid and its stored tag equals the request tag. With no refill running, a hit keeps `cpu_stall` low in the cycle the request is presented.
- R3: A miss fetches only the aligned line holding the requested word. Every `mem_addr` of the refill carries the request's tag and index in its upper bits, and each word offset of the line is fetched exactly once.
- R4: The first `mem_addr` offset of a refill equals the requested offset. Each following offset is one higher, modulo WORDS.
- R5: At most one memory request is outstanding. `mem_req` is a one-cycle strobe. It is not raised again before the response to the previous strobe has arrived, and never in the cycle right after a strobe.
- R6: In the cycle `mem_rvalid` returns the word a waiting request asks for, `cpu_stall` is low. In the next cycle `cpu_rdata` equals that `mem_rdata`.
- R7: During a refill, a request to an already written word of the filling line is served without stall. A request to any other address, even a line that was valid before, stalls until the refill ends.
- R8: The tag of a line is replaced when its refill starts. The line becomes valid only after its last word is written. Once the refill ends, every word of the line hits.
- R9: Two addresses whose distance is a multiple of LINES*WORDS words map to the same line. Reading one after the other makes the first miss again.
- R10: `cpu_rvalid` is high exactly in the cycle after each cycle with `cpu_req` high and `cpu_stall` low, and low otherwise. `cpu_rdata` then holds the memory word at the requested address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor read request, held until accepted |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_stall | output | 1 | Request cannot be accepted this cycle |
| cpu_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| cpu_rdata | output | WORD_W | Read data |
| mem_req | output | 1 | One-cycle memory read strobe |
| mem_addr | output | ADDR_W | Word address of the memory read |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | WORD_W | Memory read response data |

## Verification
A wrong tag or valid bit shows up at the ports within one cycle of the next request to that line. It appears either as a stall where a hit was due or as a hit where a refill was due, and in the second case `cpu_rdata` carries a word from another address one cycle later. A slip in the refill pointer shows in the very first `mem_addr` of a refill as a wrong offset. A slip in the written-word mask shows as a stall or early release during the background fill, seen in the cycle of the request. The bench therefore follows the refill pointer, the written mask and the line table in its own model and compares stall, memory strobe, memory address and returned data on every cycle.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    // default geometry: 4 lines of 4 words, 32-bit words, 8-bit word address
    localparam int unsigned CWF_ADDR_W = 8;
    localparam int unsigned CWF_WORD_W = 32;
    localparam int unsigned CWF_LINES  = 4;
    localparam int unsigned CWF_WORDS  = 4;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_phase_e;

endpackage

// File: rtl/cwf_addr_split.sv
module cwf_addr_split #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 2
) (
    input  logic [ADDR_W-1:0]              addr_i,
    output logic [ADDR_W-IDX_W-OFF_W-1:0]  tag_o,
    output logic [IDX_W-1:0]               idx_o,
    output logic [OFF_W-1:0]               off_o
);
    localparam int TAG_LSB = IDX_W + OFF_W;

    // R2: offset lowest, line index above it, tag in the remaining high bits
    always_comb begin
        off_o = addr_i[OFF_W-1:0];
        idx_o = addr_i[TAG_LSB-1:OFF_W];
        tag_o = addr_i[ADDR_W-1:TAG_LSB];
    end
endmodule

// File: rtl/cwf_tag_store.sv
module cwf_tag_store #(
    parameter int LINES = 4,
    parameter int TAG_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(LINES)-1:0]  look_idx_i,
    input  logic [TAG_W-1:0]          look_tag_i,
    output logic                      hit_o,
    output logic [LINES-1:0]          valid_o,
    input  logic                      alloc_i,
    input  logic [$clog2(LINES)-1:0]  alloc_idx_i,
    input  logic [TAG_W-1:0]          alloc_tag_i,
    input  logic                      fin_i,
    input  logic [$clog2(LINES)-1:0]  fin_idx_i
);
    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0][TAG_W-1:0] tags;
    } tstore_t;

    tstore_t          ts_d, ts_q;
    logic [LINES-1:0] line_match;

    // one comparator per line, the index then picks the result
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign line_match[g] = ts_q.valid[g] && (ts_q.tags[g] == look_tag_i);
    end

    assign hit_o   = line_match[look_idx_i];
    assign valid_o = ts_q.valid;

    always_comb begin
        ts_d = ts_q;
        // R8: tag replaced and line invalidated as the refill starts
        if (alloc_i) begin
            ts_d.tags[alloc_idx_i]  = alloc_tag_i;
            ts_d.valid[alloc_idx_i] = 1'b0;
        end
        // R8: line becomes valid only with its last word
        if (fin_i) begin
            ts_d.valid[fin_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    // R8
    fin_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |=> valid_o[$past(fin_idx_i)]);
endmodule

// File: rtl/cwf_fill_seq.sv
module cwf_fill_seq
    import cwf_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int IDX_W = 2,
    parameter int OFF_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [TAG_W-1:0]              start_tag_i,
    input  logic [IDX_W-1:0]              start_idx_i,
    input  logic [OFF_W-1:0]              start_off_i,
    input  logic                          mem_rvalid_i,
    output logic                          busy_o,
    output logic [TAG_W-1:0]              line_tag_o,
    output logic [IDX_W-1:0]              line_idx_o,
    output logic [(1<<OFF_W)-1:0]         written_o,
    output logic [OFF_W-1:0]              rsp_off_o,
    output logic                          wr_en_o,
    output logic                          last_o,
    output logic                          mem_req_o,
    output logic [TAG_W+IDX_W+OFF_W-1:0]  mem_addr_o
);
    localparam int WORDS = 1 << OFF_W;
    localparam int CNT_W = OFF_W + 1;

    typedef struct packed {
        fill_phase_e      phase;
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] crit;
        logic [CNT_W-1:0] issued;
        logic [CNT_W-1:0] received;
        logic             outst;
        logic [WORDS-1:0] written;
    } seq_t;

    seq_t             sq_d, sq_q;
    logic             running;
    logic             issue;
    logic [OFF_W-1:0] req_off;

    always_comb begin
        running   = (sq_q.phase == FILL_RUN);
        // R5: a new strobe only when nothing is outstanding
        issue     = running && !sq_q.outst && (sq_q.issued != CNT_W'(WORDS));
        // R4: both pointers walk upward from the missed word, wrapping
        req_off   = sq_q.crit + sq_q.issued[OFF_W-1:0];
        rsp_off_o = sq_q.crit + sq_q.received[OFF_W-1:0];
        wr_en_o   = running && mem_rvalid_i;
        last_o    = wr_en_o && (sq_q.received == CNT_W'(WORDS - 1));

        sq_d = sq_q;
        if (issue) begin
            sq_d.issued = sq_q.issued + CNT_W'(1);
            sq_d.outst  = 1'b1;
        end
        if (wr_en_o) begin
            sq_d.outst              = 1'b0;
            sq_d.written[rsp_off_o] = 1'b1;
            sq_d.received           = sq_q.received + CNT_W'(1);
            if (last_o) begin
                sq_d.phase = FILL_IDLE;
            end
        end
        if (start_i && !running) begin
            sq_d.phase    = FILL_RUN;
            sq_d.tag      = start_tag_i;
            sq_d.idx      = start_idx_i;
            sq_d.crit     = start_off_i;
            sq_d.issued   = '0;
            sq_d.received = '0;
            sq_d.outst    = 1'b0;
            sq_d.written  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    // R3: memory address keeps the filling line's tag and index
    assign mem_req_o  = issue;
    assign mem_addr_o = {sq_q.tag, sq_q.idx, req_off};
    assign busy_o     = running;
    assign line_tag_o = sq_q.tag;
    assign line_idx_o = sq_q.idx;
    assign written_o  = sq_q.written;

    // R5
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R4
    first_word_crit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (mem_req_o && mem_addr_o[OFF_W-1:0] == $past(start_off_i)));
endmodule

// File: rtl/cwf_data_store.sv
module cwf_data_store #(
    parameter int LINES  = 4,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [$clog2(LINES)-1:0]  wr_idx_i,
    input  logic [$clog2(WORDS)-1:0]  wr_off_i,
    input  logic [WORD_W-1:0]         wr_data_i,
    input  logic [$clog2(LINES)-1:0]  rd_idx_i,
    input  logic [$clog2(WORDS)-1:0]  rd_off_i,
    output logic [WORD_W-1:0]         rd_data_o
);
    localparam int ENTRIES = LINES * WORDS;
    localparam int EA_W    = $clog2(ENTRIES);

    logic [WORD_W-1:0] arr_d [ENTRIES];
    logic [WORD_W-1:0] arr_q [ENTRIES];
    logic [EA_W-1:0]   wr_ea, rd_ea;

    always_comb begin
        wr_ea = {wr_idx_i, wr_off_i};
        rd_ea = {rd_idx_i, rd_off_i};
        arr_d = arr_q;
        if (wr_en_i) begin
            arr_d[wr_ea] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                arr_q[i] <= '0;
            end
        end else begin
            arr_q <= arr_d;
        end
    end

    assign rd_data_o = arr_q[rd_ea];
endmodule

// File: rtl/cwf_cache.sv
module cwf_cache
    import cwf_pkg::*;
#(
    parameter int ADDR_W = CWF_ADDR_W,
    parameter int WORD_W = CWF_WORD_W,
    parameter int LINES  = CWF_LINES,
    parameter int WORDS  = CWF_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_stall,
    output logic              cpu_rvalid,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(WORDS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    typedef struct packed {
        logic              rvalid;
        logic [WORD_W-1:0] rdata;
    } resp_t;

    resp_t             rsp_d, rsp_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;
    logic              tag_hit;
    logic [LINES-1:0]  line_valid;

    logic              fill_busy;
    logic [TAG_W-1:0]  fill_tag;
    logic [IDX_W-1:0]  fill_idx;
    logic [WORDS-1:0]  fill_written;
    logic [OFF_W-1:0]  fill_rsp_off;
    logic              fill_wr;
    logic              fill_last;
    logic              fill_start;

    logic [WORD_W-1:0] arr_rdata;
    logic              same_line, fwd_hit, part_hit, idle_hit, serve;

    cwf_addr_split #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W)
    ) i_split (
        .addr_i (cpu_addr),
        .tag_o  (req_tag),
        .idx_o  (req_idx),
        .off_o  (req_off)
    );

    cwf_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) i_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_idx_i  (req_idx),
        .look_tag_i  (req_tag),
        .hit_o       (tag_hit),
        .valid_o     (line_valid),
        .alloc_i     (fill_start),
        .alloc_idx_i (req_idx),
        .alloc_tag_i (req_tag),
        .fin_i       (fill_last),
        .fin_idx_i   (fill_idx)
    );

    cwf_fill_seq #(
        .TAG_W (TAG_W),
        .IDX_W (IDX_W),
        .OFF_W (OFF_W)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (fill_start),
        .start_tag_i  (req_tag),
        .start_idx_i  (req_idx),
        .start_off_i  (req_off),
        .mem_rvalid_i (mem_rvalid),
        .busy_o       (fill_busy),
        .line_tag_o   (fill_tag),
        .line_idx_o   (fill_idx),
        .written_o    (fill_written),
        .rsp_off_o    (fill_rsp_off),
        .wr_en_o      (fill_wr),
        .last_o       (fill_last),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr)
    );

    cwf_data_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .WORD_W (WORD_W)
    ) i_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (fill_wr),
        .wr_idx_i  (fill_idx),
        .wr_off_i  (fill_rsp_off),
        .wr_data_i (mem_rdata),
        .rd_idx_i  (req_idx),
        .rd_off_i  (req_off),
        .rd_data_o (arr_rdata)
    );

    always_comb begin
        same_line  = fill_busy && (req_idx == fill_idx) && (req_tag == fill_tag);
        // R6: word arriving from memory this cycle is forwarded at once
        fwd_hit    = cpu_req && same_line && fill_wr && (req_off == fill_rsp_off);
        // R7: words already written during the running refill
        part_hit   = same_line && fill_written[req_off];
        // R2: ordinary lookup only when no refill runs
        idle_hit   = !fill_busy && tag_hit;
        serve      = cpu_req && (idle_hit || part_hit || fwd_hit);
        cpu_stall  = cpu_req && !serve;
        // R1/R3: a miss with the sequencer free opens a refill
        fill_start = cpu_req && !fill_busy && !tag_hit;

        rsp_d        = rsp_q;
        rsp_d.rvalid = serve;
        if (serve) begin
            rsp_d.rdata = fwd_hit ? mem_rdata : arr_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign cpu_rvalid = rsp_q.rvalid;
    assign cpu_rdata  = rsp_q.rdata;

    // R10
    accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_stall) |=> cpu_rvalid);

    // R10
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && !cpu_stall) |=> !cpu_rvalid);

    // R8
    fill_line_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy |-> !line_valid[fill_idx]);

    // R7
    busy_serve_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && cpu_req && !cpu_stall) |-> (req_idx == fill_idx && req_tag == fill_tag));

    // R6
    crit_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |=> (cpu_rdata == $past(mem_rdata)));
endmodule

// File: tb/test_cwf_cache.sv
module test_cwf_cache;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NL = 4;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_stall, cpu_rvalid, mem_req;
    logic [DW-1:0] cpu_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #2 clk = ~clk;

    cwf_cache #(.ADDR_W(AW), .WORD_W(DW), .LINES(NL), .WORDS(NW)) i_cwf_cache (
        .clk, .rst_n, .cpu_req, .cpu_addr, .cpu_stall, .cpu_rvalid, .cpu_rdata,
        .mem_req, .mem_addr, .mem_rvalid, .mem_rdata
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    function automatic logic [DW-1:0] gold(input logic [AW-1:0] a);
        return {8'hA5, a, ~a, a ^ 8'h3C};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // behavioural model state
    int m_valid[NL];
    int m_tag[NL];
    int busy = 0, f_line = 0, f_tag = 0, f_crit = 0, iss = 0, rcv = 0, outst = 0;
    int written[NW];
    int er_v = 0;
    logic [DW-1:0] er_d = '0;
    // memory model
    int mem_pend = 0, mem_cnt = 0, lat_i = 0;
    logic [AW-1:0] mem_a = '0;
    int lats[5] = '{1, 3, 2, 4, 1};
    int last_stall = 0;

    task automatic tick();
        int a, idx, off, tg, rsp_off, e_maddr;
        bit same, fwd, wrh, hit, serve, e_stall, e_mreq, start;
        // memory drives its response for this cycle
        mem_rvalid = 1'b0;
        if (mem_pend != 0) begin
            mem_cnt--;
            if (mem_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = gold(mem_a);
                mem_pend   = 0;
            end
        end
        #1;
        a   = int'(cpu_addr);
        off = a % NW;
        idx = (a / NW) % NL;
        tg  = a / (NW * NL);
        rsp_off = (f_crit + rcv) % NW;
        same  = (busy != 0) && idx == f_line && tg == f_tag;
        fwd   = cpu_req && same && mem_rvalid && off == rsp_off;
        wrh   = same && written[off] != 0;
        hit   = (busy == 0) && m_valid[idx] != 0 && m_tag[idx] == tg;
        serve = cpu_req && (hit || wrh || fwd);
        e_stall = cpu_req && !serve;
        e_mreq  = (busy != 0) && (outst == 0) && iss < NW;
        e_maddr = f_tag * NW * NL + f_line * NW + (f_crit + iss) % NW;
        start   = cpu_req && (busy == 0) && !hit;

        chk(cpu_stall == e_stall, "R7", "cpu_stall", 32'(cpu_stall), 32'(e_stall));
        chk(mem_req == e_mreq, "R5", "mem_req", 32'(mem_req), 32'(e_mreq));
        if (e_mreq)
            chk(int'(mem_addr) == e_maddr, "R4", "mem_addr", 32'(mem_addr), 32'(e_maddr));
        chk(cpu_rvalid == (er_v != 0), "R10", "cpu_rvalid", 32'(cpu_rvalid), 32'(er_v));
        if (er_v != 0)
            chk(cpu_rdata == er_d, "R6", "cpu_rdata", cpu_rdata, er_d);
        last_stall = int'(cpu_stall);

        // memory accepts a strobe
        if (mem_req) begin
            chk(mem_pend == 0, "R5", "strobe while outstanding", 32'(mem_pend), 32'd0);
            mem_pend = 1;
            mem_a    = mem_addr;
            mem_cnt  = lats[lat_i % 5];
            lat_i++;
        end

        // model advance
        er_v = int'(serve);
        if (serve) er_d = gold(cpu_addr);
        if (e_mreq) begin
            iss++;
            outst = 1;
        end
        if (busy != 0 && mem_rvalid) begin
            outst = 0;
            written[rsp_off] = 1;
            rcv++;
            if (rcv == NW) begin
                m_valid[f_line] = 1;
                busy = 0;
            end
        end
        if (start) begin
            busy = 1; f_line = idx; f_tag = tg; f_crit = off;
            iss = 0; rcv = 0; outst = 0;
            for (int w = 0; w < NW; w++) written[w] = 0;
            m_tag[idx] = tg;
            m_valid[idx] = 0;
        end
        @(negedge clk);
    endtask

    // kind: 0 any, 1 must hit in first cycle, 2 must stall in first cycle
    task automatic rd(input logic [AW-1:0] a, input int kind, input string rq);
        int n;
        cpu_req  = 1'b1;
        cpu_addr = a;
        n = 0;
        do begin
            tick();
            if (n == 0 && kind == 1)
                chk(last_stall == 0, rq, "first-cycle hit", 32'(last_stall), 32'd0);
            if (n == 0 && kind == 2)
                chk(last_stall == 1, rq, "first-cycle miss", 32'(last_stall), 32'd1);
            n++;
        end while (last_stall != 0 && n < 200);
        if (n >= 200) chk(0, rq, "request never accepted", 32'(n), 32'd0);
        cpu_req = 1'b0;
    endtask

    task automatic idle(input int n);
        cpu_req = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < NL; i++) begin
            m_valid[i] = 0;
            m_tag[i] = 0;
        end
        for (int w = 0; w < NW; w++) written[w] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk(cpu_rvalid == 1'b0, "R1", "reset cpu_rvalid", 32'(cpu_rvalid), 32'd0);
        chk(mem_req == 1'b0, "R1", "reset mem_req", 32'(mem_req), 32'd0);
        chk(cpu_stall == 1'b0, "R1", "reset cpu_stall", 32'(cpu_stall), 32'd0);
        @(negedge clk);

        rd(8'h02, 2, "R1");        // miss, fill order 2,3,0,1 (R3, R4)
        rd(8'h03, 0, "R7");        // during background fill
        rd(8'h00, 0, "R7");
        rd(8'h01, 0, "R7");
        idle(8);
        rd(8'h00, 1, "R8");
        rd(8'h03, 1, "R2");
        rd(8'h15, 2, "R2");        // line 1, offset 1
        rd(8'h16, 0, "R6");        // next word of the filling line
        idle(10);
        rd(8'h08, 2, "R4");        // offset 0, no wrap
        idle(10);
        rd(8'h12, 2, "R9");        // same line as 0x02, other tag
        idle(10);
        rd(8'h02, 2, "R9");        // evicted
        idle(10);
        rd(8'h02, 1, "R9");
        rd(8'h2B, 2, "R4");        // offset 3, wraps at once
        rd(8'h15, 2, "R7");        // valid line but refill running
        idle(10);
        rd(8'h15, 1, "R8");

        lf = 32'h1234_5678;
        for (int k = 0; k < 80; k++) begin
            lf = lf * 32'd1103515245 + 32'd12345;
            rd(lf[23:16] & 8'h3F, 0, "R10");
            idle(int'(lf[9:8]) % 3);
        end
        idle(12);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "R10", "watchdog expired", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule